// File: doc/BRIEF.md
# Hashed Page Table Group Walker

This block translates a virtual address by searching a hashed page table held in external memory. A request carries the virtual address, a page-size select, the table base address and a hash mask. The block forms a hash from the address and picks a group of eight entries. It reads the entries one per cycle through a simple read port and compares each against a virtual word it builds from the request. It stops at the first entry that matches.

If nothing in the primary group matches, the block walks the secondary group, whose index is the complemented hash. The response reports hit or fault, the real page number with its large-page encoding removed, the no-execute flag, and whether the requested supervisor or user read or write is allowed. Each table entry is 16 bytes: the virtual word sits in `mem_rdata[127:64]` and the real word in `mem_rdata[63:0]`. The memory returns data one cycle after `mem_rd`.

Top module: `hpt_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `resp_valid` is 0 and `mem_rd` is 0. No memory read is issued while the block is idle.
- R2: A request is accepted only when `req_valid` and `req_ready` are both high. `req_ready` drops in the next cycle, a `req_valid` seen while busy is ignored, and every accepted request yields exactly one one-cycle `resp_valid` pulse.
- R3: The page-shift is 12, 16, 20 or 24 for `req_psel` 0, 1, 2 or 3. The hash is (va >> 28, kept to 39 bits) XOR (va[27:0] >> shift). The primary group address is `tbl_base + ((hash & hash_mask) << 7)`. Entries are read at the group address plus 16·slot, slots 0 to 7 in order, one read per cycle. `tbl_base` must be 128-byte aligned.
- R4: The request word is ((va >> 23) with bit 0 cleared when `req_psel`=3) << 7. An entry matches when its virtual word has bit 0 (valid) set, its bit 1 (secondary) equal to the current pass, and bits [63:7] equal to the request word. Bits [6:2] of the virtual word are ignored.
- R5: On a match at primary slot k, `resp_valid` rises at the (2+k)-th rising edge after the accepting edge. No later slot is examined.
- R6: After eight primary slots without a match, the block searches the group at `tbl_base + ((~hash & hash_mask) << 7)`. There only entries with the secondary bit set can match. A match at slot k responds at the (11+k)-th edge after acceptance.
- R7: When neither group matches, the response comes at the 18th edge after acceptance with `resp_fault`=1, `resp_hit`=0, `resp_perm_ok`=0 and `resp_rpn`=0.
- R8: On a hit, `resp_rpn` is real-word bits [61:12] with the low (shift−12) bits cleared, and `resp_nx` is real-word bit 2.
- R9: The protection code is real-word bits [1:0]. Code 0 lets the supervisor read and write and gives the user nothing. Code 1 lets the supervisor read and write and lets the user read. Code 2 lets both read and write. Code 3 lets both read only. `resp_perm_ok` reports whether the access given by `req_user` and `req_write` is allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_va | input | VA_W | Virtual address |
| req_psel | input | 2 | Page size: 0=4 KB, 1=64 KB, 2=1 MB, 3=16 MB |
| req_user | input | 1 | 1 = user access, 0 = supervisor |
| req_write | input | 1 | 1 = write, 0 = read |
| tbl_base | input | ADDR_W | Table base byte address |
| hash_mask | input | HASH_W | Mask applied to the hash to form the group index |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W | Entry byte address |
| mem_rdata | input | 128 | Entry returned one cycle after the read |
| resp_valid | output | 1 | Response pulse |
| resp_hit | output | 1 | Translation found |
| resp_fault | output | 1 | No entry in either group |
| resp_perm_ok | output | 1 | Access allowed |
| resp_nx | output | 1 | No-execute flag of the hit entry |
| resp_rpn | output | 50 | Real page number, aligned to the page size |

## Verification
The bench uses the default widths: 64-bit address, 39-bit hash and eight-entry groups. It sets `hash_mask` to 3, so the table is four groups (32 entries) held in a small bench memory. With only four groups, the primary and secondary groups of one address are always distinct yet close together. A decoy entry can therefore be placed in each to probe the secondary-bit gating. The full primary, secondary and fault latencies of 2+k, 11+k and 18 edges are measured on every request.

// File: rtl/hpt_walker.sv
module hpt_walker #(
  parameter int VA_W    = 64,
  parameter int ADDR_W  = 64,
  parameter int HASH_W  = 39,
  parameter int GROUP_N = 8
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_va,
  input  logic [1:0]        req_psel,
  input  logic              req_user,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic [HASH_W-1:0] hash_mask,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [127:0]      mem_rdata,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic              resp_fault,
  output logic              resp_perm_ok,
  output logic              resp_nx,
  output logic [49:0]       resp_rpn
);
  localparam int IDX_W  = $clog2(GROUP_N);
  localparam int GRP_SH = IDX_W + 4;

  logic              busy, pass, chk_vld;
  logic [IDX_W:0]    iss;
  logic [IDX_W-1:0]  chk_idx;
  logic [63:0]       q_vw;
  logic [ADDR_W-1:0] q_prim, q_sec;
  logic [4:0]        q_sh;
  logic              q_user, q_write;

  logic [4:0]        sh_in;
  logic [HASH_W-1:0] hash;
  logic [63:0]       vw_req, ev, er;
  logic              hit_now, last, ok;
  logic [49:0]       pg_mask;

  assign sh_in  = 5'd12 + {1'b0, req_psel, 2'b00};
  assign hash   = HASH_W'(req_va >> 28) ^ HASH_W'(req_va[27:0] >> sh_in);
  assign vw_req = (64'(req_va >> 23) & ~64'(req_psel == 2'd3)) << 7;

  assign {ev, er}  = mem_rdata;
  assign req_ready = !busy;
  assign mem_rd    = busy && !iss[IDX_W];
  assign mem_addr  = (pass ? q_sec : q_prim) + (ADDR_W'(iss[IDX_W-1:0]) << 4);

  assign hit_now = chk_vld && ev[0] && (ev[1] == pass) &&
                   (((ev ^ q_vw) & ~64'h7F) == 64'd0);
  assign last    = chk_vld && (chk_idx == IDX_W'(GROUP_N - 1));
  assign pg_mask = ~((50'd1 << (q_sh - 5'd12)) - 50'd1);

  always_comb begin
    case (er[1:0])
      2'd0:    ok = !q_user;
      2'd1:    ok = !q_user || !q_write;
      2'd2:    ok = 1'b1;
      default: ok = !q_write;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; pass <= 1'b0; chk_vld <= 1'b0;
      iss <= '0; chk_idx <= '0; q_vw <= '0;
      q_prim <= '0; q_sec <= '0; q_sh <= 5'd12;
      q_user <= 1'b0; q_write <= 1'b0;
      resp_valid <= 1'b0; resp_hit <= 1'b0; resp_fault <= 1'b0;
      resp_perm_ok <= 1'b0; resp_nx <= 1'b0; resp_rpn <= '0;
    end else begin
      resp_valid <= 1'b0;
      if (!busy) begin
        if (req_valid) begin
          busy    <= 1'b1;
          pass    <= 1'b0;
          chk_vld <= 1'b0;
          iss     <= '0;
          q_vw    <= vw_req;
          q_sh    <= sh_in;
          q_user  <= req_user;
          q_write <= req_write;
          q_prim  <= tbl_base + (ADDR_W'(hash & hash_mask) << GRP_SH);
          q_sec   <= tbl_base + (ADDR_W'(~hash & hash_mask) << GRP_SH);
        end
      end else begin
        chk_vld <= mem_rd;
        chk_idx <= iss[IDX_W-1:0];
        if (mem_rd) iss <= iss + (IDX_W+1)'(1);
        if (hit_now) begin
          busy         <= 1'b0;
          chk_vld      <= 1'b0;
          resp_valid   <= 1'b1;
          resp_hit     <= 1'b1;
          resp_fault   <= 1'b0;
          resp_perm_ok <= ok;
          resp_nx      <= er[2];
          resp_rpn     <= 50'((er << 2) >> 14) & pg_mask;
        end else if (last) begin
          chk_vld <= 1'b0;
          if (!pass) begin
            pass <= 1'b1;
            iss  <= '0;
          end else begin
            busy         <= 1'b0;
            resp_valid   <= 1'b1;
            resp_hit     <= 1'b0;
            resp_fault   <= 1'b1;
            resp_perm_ok <= 1'b0;
            resp_nx      <= 1'b0;
            resp_rpn     <= '0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/hpt_walker_chk.sv
module hpt_walker_chk #(
  parameter int ADDR_W = 64
)(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              mem_rd,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              resp_valid,
  input logic              resp_hit,
  input logic              resp_fault,
  input logic              resp_perm_ok
);
  logic pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      pend <= 1'b0;
    else if (req_valid && req_ready) pend <= 1'b1;
    else if (resp_valid)             pend <= 1'b0;
  end

  a_r1_no_read_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_rd);
  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);
  a_r2_resp_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> pend);
  a_r2_resp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);
  a_r3_entry_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> mem_addr[3:0] == 4'd0);
  a_r7_hit_or_fault: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (resp_hit != resp_fault));
  a_r9_fault_denies: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_fault |-> !resp_perm_ok);
endmodule

bind hpt_walker hpt_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .mem_rd(mem_rd), .mem_addr(mem_addr), .resp_valid(resp_valid),
  .resp_hit(resp_hit), .resp_fault(resp_fault), .resp_perm_ok(resp_perm_ok)
);

// File: tb/sim_hpt_walker.sv
module sim_hpt_walker;
  localparam logic [63:0] BASE = 64'h4000;
  localparam logic [38:0] MASK = 39'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_user = 1'b0, req_write = 1'b0;
  logic [63:0] req_va = '0;
  logic [1:0] req_psel = '0;
  logic req_ready, mem_rd;
  logic [63:0] mem_addr;
  logic [127:0] mem_rdata = '0;
  logic resp_valid, resp_hit, resp_fault, resp_perm_ok, resp_nx;
  logic [49:0] resp_rpn;

  logic [127:0] tbl [0:31];
  logic [63:0] rd_log [0:31];
  int rd_n = 0;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  hpt_walker u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .req_psel(req_psel), .req_user(req_user), .req_write(req_write),
    .tbl_base(BASE), .hash_mask(MASK), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .resp_valid(resp_valid), .resp_hit(resp_hit),
    .resp_fault(resp_fault), .resp_perm_ok(resp_perm_ok), .resp_nx(resp_nx),
    .resp_rpn(resp_rpn)
  );

  always @(posedge clk) begin
    if (mem_rd) begin
      mem_rdata <= tbl[5'((mem_addr - BASE) >> 4)];
      if (rd_n < 32) rd_log[rd_n] <= mem_addr;
      rd_n <= rd_n + 1;
    end
  end

  initial begin
    #4000000;
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] gaddr(input logic [63:0] va, input logic [1:0] ps, input bit sec);
    logic [38:0] h;
    int sh = 12 + 4 * ps;
    h = 39'(va >> 28) ^ 39'((va & 64'h0FFF_FFFF) >> sh);
    if (sec) h = ~h;
    return BASE + (64'(h & MASK) * 128);
  endfunction

  function automatic int slot(input logic [63:0] va, input logic [1:0] ps, input bit sec, input int k);
    return int'((gaddr(va, ps, sec) - BASE) / 16) + k;
  endfunction

  function automatic logic [127:0] ent(input logic [63:0] va, input logic [1:0] ps,
      input bit sec, input bit vld, input logic [49:0] rpn, input bit nx, input logic [1:0] pp);
    logic [63:0] v, r;
    v = (va >> 23);
    if (ps == 2'd3) v[0] = 1'b0;
    v = (v * 128) | {59'd0, 1'b0, 1'b0, ps != 2'd0, sec, vld};
    r = {2'b00, rpn, 9'd0, nx, pp};
    return {v, r};
  endfunction

  task automatic clear_tbl();
    for (int i = 0; i < 32; i++) tbl[i] = '0;
  endtask

  task automatic run(input logic [63:0] va, input logic [1:0] ps, input bit u, input bit w,
                     output int lat);
    @(negedge clk);
    rd_n <= 0;
    req_va = va; req_psel = ps; req_user = u; req_write = w; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!resp_valid && lat < 60) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic t_reset();
    chk("R1 ready", 64'(req_ready), 1);
    chk("R1 resp_valid", 64'(resp_valid), 0);
    chk("R1 mem_rd", 64'(mem_rd), 0);
  endtask

  task automatic t_prim_hit();
    int lat;
    logic [63:0] va = 64'h0000_0012_3456_7000;
    clear_tbl();
    tbl[slot(va, 0, 0, 0)] = ent(va, 0, 0, 1, 50'h1_2345, 1, 2'd2);
    run(va, 0, 1, 1, lat);
    chk("R5 primary slot0 latency", 64'(lat), 2);
    chk("R5 hit", 64'(resp_hit), 1);
    chk("R8 rpn 4K", 64'(resp_rpn), 64'h1_2345);
    chk("R8 nx", 64'(resp_nx), 1);
    chk("R3 first read address", rd_log[0], gaddr(va, 0, 0));
    @(negedge clk);
    chk("R2 response is one pulse", 64'(resp_valid), 0);
    chk("R2 ready after response", 64'(req_ready), 1);
  endtask

  task automatic t_prim_later();
    int lat;
    logic [63:0] va = 64'h0000_00AB_0C0D_5000;
    logic [63:0] other = va + 64'h0080_0000;
    clear_tbl();
    tbl[slot(va, 0, 0, 1)] = ent(va, 0, 0, 0, 50'h111, 0, 2'd0);
    tbl[slot(va, 0, 0, 2)] = ent(va, 0, 1, 1, 50'h222, 0, 2'd0);
    tbl[slot(va, 0, 0, 3)] = ent(other, 0, 0, 1, 50'h333, 0, 2'd0);
    tbl[slot(va, 0, 0, 5)] = ent(va, 0, 0, 1, 50'h555, 0, 2'd0);
    tbl[slot(va, 0, 0, 6)] = ent(va, 0, 0, 1, 50'h666, 0, 2'd0);
    run(va, 0, 0, 0, lat);
    chk("R4 skip invalid/secondary/other, hit slot5 rpn", 64'(resp_rpn), 64'h555);
    chk("R5 primary slot5 latency", 64'(lat), 7);
    chk("R3 second read address", rd_log[1], gaddr(va, 0, 0) + 16);
    chk("R3 sixth read address", rd_log[5], gaddr(va, 0, 0) + 80);
  endtask

  task automatic t_sec_hit();
    int lat;
    logic [63:0] va = 64'h0000_0003_0004_2000;
    clear_tbl();
    tbl[slot(va, 1, 1, 0)] = ent(va, 1, 0, 1, 50'h7770, 0, 2'd1);
    tbl[slot(va, 1, 1, 4)] = ent(va, 1, 1, 1, 50'h8888F, 0, 2'd1);
    run(va, 1, 1, 0, lat);
    chk("R6 secondary hit", 64'(resp_hit), 1);
    chk("R6 secondary slot4 latency", 64'(lat), 15);
    chk("R8 rpn 64K aligned", 64'(resp_rpn), 64'h88880);
    chk("R6 secondary first read", rd_log[8], gaddr(va, 1, 1));
    chk("R9 code1 user read", 64'(resp_perm_ok), 1);
  endtask

  task automatic t_miss();
    int lat;
    logic [63:0] va = 64'h0000_0777_0123_4000;
    clear_tbl();
    tbl[slot(va, 0, 0, 7)] = ent(va, 0, 1, 1, 50'h1, 0, 2'd2);
    tbl[slot(va, 0, 1, 3)] = ent(va, 0, 0, 1, 50'h2, 0, 2'd2);
    run(va, 0, 0, 0, lat);
    chk("R7 miss latency", 64'(lat), 18);
    chk("R7 fault", 64'(resp_fault), 1);
    chk("R7 no hit", 64'(resp_hit), 0);
    chk("R7 perm denied", 64'(resp_perm_ok), 0);
    chk("R7 rpn zero", 64'(resp_rpn), 0);
  endtask

  task automatic t_perm();
    int lat;
    logic [63:0] va = 64'h0000_0001_0000_3000;
    for (int c = 0; c < 4; c++) begin
      for (int u = 0; u < 2; u++) begin
        for (int w = 0; w < 2; w++) begin
          bit exp;
          clear_tbl();
          tbl[slot(va, 0, 0, 0)] = ent(va, 0, 0, 1, 50'h9, 0, 2'(c));
          exp = (c == 2) || (c == 0 && u == 0) || (c == 1 && (u == 0 || w == 0)) ||
                (c == 3 && w == 0);
          run(va, 0, 1'(u), 1'(w), lat);
          chk($sformatf("R9 code%0d user%0d write%0d", c, u, w), 64'(resp_perm_ok), 64'(exp));
        end
      end
    end
  endtask

  task automatic t_huge();
    int lat;
    logic [63:0] va = 64'h0000_0042_0080_0000;
    clear_tbl();
    tbl[slot(va, 3, 0, 2)] = ent(va & ~64'h0080_0000, 3, 0, 1, 50'h3_4ABC, 0, 2'd3);
    run(va, 3, 0, 0, lat);
    chk("R4 16M ignores va bit23", 64'(resp_hit), 1);
    chk("R5 16M slot2 latency", 64'(lat), 4);
    chk("R8 rpn 16M aligned", 64'(resp_rpn), 64'h3_4000);
    chk("R9 code3 supervisor read", 64'(resp_perm_ok), 1);
    clear_tbl();
    tbl[slot(va, 2, 0, 0)] = ent(va, 2, 0, 1, 50'h5_67FF, 0, 2'd2);
    run(va, 2, 0, 0, lat);
    chk("R8 rpn 1M aligned", 64'(resp_rpn), 64'h5_6700);
  endtask

  task automatic t_busy_ignore();
    int resp_n = 0;
    logic [63:0] va = 64'h0000_0005_0600_1000;
    logic [63:0] vb = 64'h0000_0009_0000_9000;
    clear_tbl();
    tbl[slot(va, 0, 0, 3)] = ent(va, 0, 0, 1, 50'hA3, 0, 2'd2);
    tbl[slot(vb, 0, 0, 0)] = ent(vb, 0, 0, 1, 50'hB0, 0, 2'd2);
    @(negedge clk);
    req_va = va; req_psel = 0; req_valid = 1'b1;
    @(negedge clk);
    req_va = vb;
    chk("R2 not ready while busy", 64'(req_ready), 0);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (i == 1) req_valid = 1'b0;
      if (resp_valid) begin
        resp_n++;
        chk("R2 response belongs to accepted request", 64'(resp_rpn), 64'hA3);
      end
    end
    chk("R2 exactly one response", 64'(resp_n), 1);
  endtask

  initial begin
    clear_tbl();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_prim_hit();
    t_prim_later();
    t_sec_hit();
    t_miss();
    t_perm();
    t_huge();
    t_busy_ignore();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule